// File: doc/BRIEF.md
# Load-Multiple Word Sequencer

This block carries out a load-multiple-word operation for an integer core. A one-cycle start pulse supplies a 5-bit first destination register index, a 32-bit base address and a 16-bit signed displacement. The sequencer forms the first effective address as the base plus the sign-extended displacement. It then reads one word at a time from memory and writes each returned word into the register file. The first word goes to the named register and each later word goes to the next register up. The run always ends with register 31, so a lower first index means more loads: the number of loads is 32 minus the first index.

The memory request side is a valid/ready channel. A request stays valid with its address unchanged until the memory accepts it, and the memory may hold ready low for any number of cycles to apply back-pressure. Only one request is ever outstanding. The response side is a valid-only channel, and the sequencer accepts a response only while it waits for the word it asked for. Each accepted response drives a single-cycle write on the register file port in the same cycle. Control and status are plain pins: busy covers the whole run, and done pulses once after the last register is written.

Top module: `mwl_seq`

## Requirements
- R1: After reset, busy, done, mem_req_valid and rf_we are all low.
- R2: The first memory request address equals base_addr plus disp sign-extended from bit 15 (disp 0xFFF0 means minus 16).
- R3: The first returned word is written to register first_reg, and each later word to the register one higher, in the order the words return.
- R4: The run ends after register 31 is written, so exactly 32 minus first_reg requests are issued (1 for index 31, 32 for index 0).
- R5: Each request address is 4 greater than the previous request address of the same run.
- R6: While mem_req_valid is high and mem_req_ready is low, the request stays valid with the same address in the next cycle.
- R7: rf_we is high only in the cycle a response is accepted for an outstanding request, and it then carries mem_rsp_data. A mem_rsp_valid while no request is outstanding writes nothing.
- R8: busy rises in the cycle after an accepted start and stays high through the done cycle. done is high for exactly one cycle, right after the write to register 31, and busy is low in the following cycle.
- R9: A start pulse while busy is high is ignored: the run in progress keeps its registers and its request count, and done pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| first_reg | input | 5 | First destination register index |
| base_addr | input | 32 | Base address |
| disp | input | 16 | Signed displacement |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle pulse after the last register write |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The sequence is run from first indices 0, 29 and 31 and from one index in between. These runs tell a correct run length (32, 3 and 1 loads) apart from an off-by-one at either end of the register range. One run uses a negative displacement, which separates sign extension from zero extension, and the run at index 29 reproduces a known address and register pattern. The memory model varies its response latency and holds ready low on some cycles, which exposes a request address that moves under back-pressure. Stray response and start pulses, given while idle and during a run, show whether the register file or the run can be disturbed from outside.

// File: rtl/mwl_pkg.sv
package mwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } mwl_state_e;
endpackage

// File: rtl/mwl_cursor.sv
// Address and register-index cursor for one load-multiple run.
module mwl_cursor #(
  parameter int AW    = 32,
  parameter int IDXW  = 5,
  parameter int DISPW = 16,
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    base,
  input  logic [DISPW-1:0] disp,
  input  logic [IDXW-1:0]  first,
  output logic [AW-1:0]    addr,
  output logic [IDXW-1:0]  idx,
  output logic             at_last
);
  localparam logic [IDXW-1:0] LAST_IDX = {IDXW{1'b1}};
  localparam logic [AW-1:0]   STEP_B   = AW'(BYTES);

  logic [AW-1:0] disp_ext;
  assign disp_ext = {{(AW-DISPW){disp[DISPW-1]}}, disp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      idx  <= '0;
    end else if (load) begin
      addr <= base + disp_ext;
      idx  <= first;
    end else if (step) begin
      addr <= addr + STEP_B;
      idx  <= idx + 1'b1;
    end
  end

  assign at_last = (idx == LAST_IDX);
endmodule

// File: rtl/mwl_ctrl.sv
// Control state machine: one outstanding read, one write per response.
module mwl_ctrl
  import mwl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic at_last,
  output logic load,
  output logic step,
  output logic req_valid,
  output logic wr_en,
  output logic busy,
  output logic done
);
  mwl_state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt  = st;
    load = 1'b0;
    step = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        load = 1'b1;
        nxt  = ST_REQ;
      end
      ST_REQ:  if (req_ready) nxt = ST_WAIT;
      ST_WAIT: if (rsp_valid) begin
        if (at_last) nxt = ST_DONE;
        else begin
          step = 1'b1;
          nxt  = ST_REQ;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign req_valid = (st == ST_REQ);
  assign wr_en     = (st == ST_WAIT) && rsp_valid;
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);

  // R6: an unaccepted request is still offered next cycle
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);
  // R8: busy only rises after a start pulse
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R8: busy drops right after done
  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9: start during a run does not restart the cursor
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |-> !load);
endmodule

// File: rtl/mwl_seq.sv
// Load-multiple word sequencer top.
module mwl_seq #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDXW  = 5,
  parameter int DISPW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDXW-1:0]  first_reg,
  input  logic [AW-1:0]    base_addr,
  input  logic [DISPW-1:0] disp,
  output logic             busy,
  output logic             done,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [DW-1:0]    mem_rsp_data,
  output logic             rf_we,
  output logic [IDXW-1:0]  rf_waddr,
  output logic [DW-1:0]    rf_wdata
);
  localparam int              BYTES    = DW / 8;
  localparam logic [IDXW-1:0] LAST_IDX = {IDXW{1'b1}};

  logic load, step, at_last;

  mwl_cursor #(.AW(AW), .IDXW(IDXW), .DISPW(DISPW), .BYTES(BYTES)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base(base_addr), .disp(disp), .first(first_reg),
    .addr(mem_req_addr), .idx(rf_waddr), .at_last(at_last)
  );

  mwl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .at_last(at_last),
    .load(load), .step(step), .req_valid(mem_req_valid), .wr_en(rf_we),
    .busy(busy), .done(done)
  );

  assign rf_wdata = mem_rsp_data;

  // R6: address holds while the request is stalled
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr));
  // R3 / R5: after a non-final write, the next request targets the next word and register
  assert_next_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_waddr != LAST_IDX |=> mem_req_valid
      && rf_waddr == IDXW'($past(rf_waddr) + 1'b1)
      && mem_req_addr == AW'($past(mem_req_addr) + AW'(BYTES)));
  // R4 / R8: done follows the write of the last register
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rf_we) && $past(rf_waddr) == LAST_IDX);
  // R7: no write outside a run
  assert_write_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy && !mem_req_valid);
endmodule

// File: tb/mwl_seq_tb.sv
module mwl_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  first_reg = '0;
  logic [31:0] base_addr = '0;
  logic [15:0] disp = '0;
  logic        busy, done, mem_req_valid, rf_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, rf_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [4:0]  rf_waddr;

  always #5 clk = ~clk;

  mwl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_reg(first_reg),
    .base_addr(base_addr), .disp(disp), .busy(busy), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata)
  );

  int checks = 0, fails = 0;
  localparam logic [31:0] SENT = 32'hBAD0_0BAD;

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C3C_A5A5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // memory / observer model state
  int          lat = 0, stall = 0, cyc = 0, lat_cnt = 0;
  bit          pending = 0, inject = 0, prev_stalled = 0;
  logic [31:0] pend_addr = '0, prev_addr = '0, exp_addr = '0;
  logic [4:0]  exp_idx = '0;
  int          req_cnt = 0, addr_err = 0, idx_err = 0, data_err = 0, stall_err = 0;
  int          stray_wr = 0, done_cnt = 0, done_nobusy = 0;
  logic [31:0] rf_m [32];

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (inject) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hDEAD_BEEF;
    end else if (pending) begin
      if (lat_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_fn(pend_addr);
        pending = 0;
      end else lat_cnt--;
    end
    mem_req_ready = (stall == 0) || (cyc % (stall + 1) == 0);
    if (rst_n) begin
      if (prev_stalled && (!mem_req_valid || mem_req_addr != prev_addr)) stall_err++;
      prev_stalled = mem_req_valid && !mem_req_ready;
      prev_addr    = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        req_cnt++;
        if (mem_req_addr != exp_addr) addr_err++;
        exp_addr  = exp_addr + 32'd4;
        pending   = 1;
        pend_addr = mem_req_addr;
        lat_cnt   = lat;
      end
    end
    #1;
    if (rst_n && rf_we) begin
      if (!busy || inject) stray_wr++;
      if (rf_waddr != exp_idx) idx_err++;
      if (rf_wdata != mem_fn(exp_addr - 32'd4)) data_err++;
      exp_idx = exp_idx + 5'd1;
      rf_m[rf_waddr] = rf_wdata;
    end
    if (rst_n && done) begin
      done_cnt++;
      if (!busy) done_nobusy++;
    end
  end

  task automatic run_seq(input logic [4:0] f, input logic [31:0] b, input logic [15:0] d,
                         input int l, input int s, input bit restart_mid);
    logic [31:0] ea;
    int d0, guard;
    ea = b + {{16{d[15]}}, d};
    for (int i = 0; i < 32; i++) rf_m[i] = SENT;
    lat = l; stall = s;
    req_cnt = 0; addr_err = 0; idx_err = 0; data_err = 0; stall_err = 0; stray_wr = 0;
    exp_addr = ea; exp_idx = f; d0 = done_cnt; done_nobusy = 0;
    @(negedge clk);
    start = 1'b1; first_reg = f; base_addr = b; disp = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8", "busy after start", 32'(busy), 1);
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1; first_reg = 5'd0; base_addr = 32'h7000_0000; disp = 16'h0;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R8", "busy low after done", 32'(busy), 0);
    chk(done_cnt - d0 == 1 && done_nobusy == 0, "R8", "single done pulse with busy",
        32'(done_cnt - d0), 1);
    chk(req_cnt == 32 - int'(f), restart_mid ? "R9" : "R4", "request count",
        32'(req_cnt), 32'(32 - int'(f)));
    chk(addr_err == 0, "R5", "request address sequence", 32'(addr_err), 0);
    chk(idx_err == 0 && data_err == 0 && stray_wr == 0, "R7", "write index/data",
        32'(idx_err + data_err + stray_wr), 0);
    chk(stall_err == 0, "R6", "request held under back-pressure", 32'(stall_err), 0);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] e;
      e = (i >= int'(f)) ? mem_fn(ea + 32'(4 * (i - int'(f)))) : SENT;
      if (rf_m[i] !== e) chk(0, "R3", $sformatf("register %0d", i), rf_m[i], e);
    end
    chk(1, "R3", "register contents", 0, 0);
  endtask

  task automatic test_reset;
    chk(!busy && !done && !mem_req_valid && !rf_we, "R1", "outputs after reset",
        {28'd0, busy, done, mem_req_valid, rf_we}, 0);
  endtask

  task automatic test_example_r29;
    run_seq(5'd29, 32'h2000_0000, 16'h0020, 0, 0, 0);
    chk(rf_m[29] == mem_fn(32'h2000_0020), "R2", "r29 from 0x20000020", rf_m[29], mem_fn(32'h2000_0020));
    chk(rf_m[31] == mem_fn(32'h2000_0028), "R5", "r31 from 0x20000028", rf_m[31], mem_fn(32'h2000_0028));
  endtask

  task automatic test_negative_disp_r31;
    run_seq(5'd31, 32'h0000_0100, 16'hFFF0, 1, 0, 0);
    chk(rf_m[31] == mem_fn(32'h0000_00F0), "R2", "sign-extended displacement", rf_m[31], mem_fn(32'h0000_00F0));
    chk(rf_m[30] == SENT, "R4", "r30 untouched", rf_m[30], SENT);
  endtask

  task automatic test_full_r0;
    run_seq(5'd0, 32'h0000_1000, 16'h0000, 0, 0, 0);
  endtask

  task automatic test_backpressure_restart;
    run_seq(5'd20, 32'h1234_5670, 16'h7FFC, 2, 2, 1);
  endtask

  task automatic test_stray_response;
    int w0;
    w0 = stray_wr;
    @(negedge clk);
    inject = 1;
    repeat (3) @(negedge clk);
    inject = 0;
    @(negedge clk);
    chk(stray_wr == w0 && !busy, "R7", "stray response while idle", 32'(stray_wr - w0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_example_r29();
    test_negative_disp_r31();
    test_full_r0();
    test_backpressure_restart();
    test_stray_response();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule